// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is a two-wire (I2C) slave that behaves like a 1024-byte serial EEPROM. It runs on a fast system clock. It oversamples the bus clock and data lines and pulls the data line low through an open-drain enable. It finds START and STOP conditions, shifts bytes in and out, and answers every byte with ACK or NACK. The storage is a small internal byte array.

A transfer opens with a header byte. Its upper nibble must be the EEPROM type code 1010 and the next bit must match a strap input. Two bank bits follow and pick one of four 256-byte banks, and the last bit selects read or write. In a write, a word address byte follows, then one or more data bytes. A read can continue from the internal pointer, or it can follow a write header and word address that are cut short by a repeated START. The self-timed programming cycle lives in a neighbouring block. This block gives that neighbour a start pulse after a write, and it reads back a busy flag, which it uses to refuse its address while programming is under way.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset the slave does not drive the data line (sda_oe = 0) and prog_start_o is 0.
- R2: A header byte is {4'b1010, strap bit equal to dev_sel_i, two bank bits, R/W} sent MSB first, where R/W = 1 means read. On a match the slave pulls SDA low during the ninth clock. If the type code or the strap bit differs, the slave gives no ACK and ignores all later bytes (no ACK, no data, no storage change) until the next START or STOP.
- R3: A write header, then a word address W, then a data byte D, stores D at array address {bank, W}. The slave ACKs each of these bytes.
- R4: In a multi-byte write each further data byte goes to the next address. Only the low 4 address bits count, so a write that passes the end of a 16-byte page wraps to the start of that same page.
- R5: A read header that comes without a preceding word address returns the byte at the pointer. The pointer holds the last accessed address plus one, and this holds after reads and after writes.
- R6: A write header and word address, followed by a repeated START and a read header, return the byte at that address.
- R7: While the master ACKs, a read goes on with the next address. The full 10-bit pointer counts, so address 1023 is followed by address 0.
- R8: After the master NACKs a read byte, the slave releases SDA and sends no more data until a new START.
- R9: While prog_busy_i is 1 the slave does not ACK its own header.
- R10: prog_start_o pulses for exactly one cycle after a STOP, and only if at least one data byte was written since the previous STOP.
- R11: A START in any state abandons the current transfer, and the next byte is taken as a header.
- R12: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| dev_sel_i | input | 1 | Strap bit compared with header bit 3 |
| prog_busy_i | input | 1 | Programming cycle in progress |
| prog_start_o | output | 1 | One-cycle request to start programming |

## Verification
The bench keeps its own byte map and pointer model, and it checks every ACK bit and every returned byte against them. It targets the page wrap, where a design that carried into the upper bits would spill the data into the next page. It also targets the 1023-to-0 read wrap, where a design that kept the bank bits fixed would return the wrong byte. A header with a wrong strap or type code is followed by address and data bytes. A design that did not stay quiet would then acknowledge them and change the stored byte. A START is placed in the middle of a data byte, where a design that kept counting bits would misread the following header. Each clock the bench also flags any change of the slave's drive while SCL is high.

// File: rtl/ee_i2c_pkg.sv
// Shared definitions for the serial EEPROM slave engine.
package ee_i2c_pkg;
    // Fixed device type code expected in the upper header nibble
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    // Protocol states of the slave
    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed, watching for START
        ST_DEV,    // receiving header byte
        ST_WORD,   // receiving word address
        ST_WDATA,  // receiving write data
        ST_ACK,    // driving the acknowledge bit
        ST_RDATA,  // transmitting a read byte
        ST_RACK    // sampling the master's acknowledge
    } slv_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes SCL and SDA into the system clock domain and derives
// clock edges and START/STOP events.
// Assumes: SCL/SDA stay at each level for several system clocks.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [1:0] raw;
    logic [1:0] lvl;
    logic [1:0] lvl_q;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        // Metastability chain for one bus line, idle high
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], raw[g]};
        end
        assign lvl[g] = pipe[STAGES-1];
    end

    // Previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 2'b11;
        else        lvl_q <= lvl;
    end

    assign sda_lvl  = lvl[0];
    assign scl_rise = lvl[1] & ~lvl_q[1];
    assign scl_fall = ~lvl[1] & lvl_q[1];
    assign start_ev = lvl[1] & lvl_q[1] & lvl_q[0] & ~lvl[0];
    assign stop_ev  = lvl[1] & lvl_q[1] & ~lvl_q[0] & lvl[0];
endmodule

// File: rtl/eeprom_store.sv
// Byte array with one synchronous write port and an asynchronous read port.
// Assumes: contents are undefined until written.
module eeprom_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Store one byte per write strobe
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/eeprom_i2c_slave.sv
// Two-wire slave engine emulating a banked serial EEPROM.
// Assumes: the system clock is much faster than SCL; the programming cycle
// is timed elsewhere and reported on prog_busy_i.
module eeprom_i2c_slave #(
    parameter int ADDR_W      = 10,
    parameter int BLK_W       = 2,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    input  logic dev_sel_i,
    input  logic prog_busy_i,
    output logic prog_start_o
);
    import ee_i2c_pkg::*;

    localparam int WORD_W = ADDR_W - BLK_W;

    logic sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    slv_state_t state, nxt_state;
    logic [2:0]        bit_cnt;
    logic [6:0]        rx_sh;
    logic [6:0]        tx_sh;
    logic              ack_on;
    logic              wrote;
    logic [BLK_W-1:0]  blk_q;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] page_next;
    logic [7:0]        rx_byte;
    logic [7:0]        rd_byte;
    logic              hdr_ok;
    logic              mem_we;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    eeprom_store #(.ADDR_W(ADDR_W), .DATA_W(8)) store_i (
        .clk(clk), .we(mem_we), .waddr(ptr), .wdata(rx_byte),
        .raddr(ptr), .rdata(rd_byte)
    );

    assign rx_byte   = {rx_sh, sda_lvl};
    assign hdr_ok    = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3] == dev_sel_i) && !prog_busy_i;
    assign mem_we    = (state == ST_WDATA) && scl_rise && (bit_cnt == 3'd7);
    assign page_next = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};

    // Protocol sequencer: bit shifting, acknowledges and pointer updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            nxt_state <= ST_IDLE;
            bit_cnt   <= 3'd0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            ack_on    <= 1'b0;
            blk_q     <= '0;
            ptr       <= '0;
            sda_oe    <= 1'b0;
        end else if (start_ev) begin
            state   <= ST_DEV;
            bit_cnt <= 3'd0;
            ack_on  <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (stop_ev) begin
            state  <= ST_IDLE;
            ack_on <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_DEV, ST_WORD, ST_WDATA: begin
                    if (scl_rise) begin
                        rx_sh   <= rx_byte[6:0];
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            state  <= ST_ACK;
                            ack_on <= 1'b0;
                            if (state == ST_DEV) begin
                                if (hdr_ok) begin
                                    blk_q     <= rx_byte[BLK_W:1];
                                    nxt_state <= rx_byte[0] ? ST_RDATA : ST_WORD;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_WORD) begin
                                ptr       <= {blk_q, rx_byte[WORD_W-1:0]};
                                nxt_state <= ST_WDATA;
                            end else begin
                                ptr       <= page_next;
                                nxt_state <= ST_WDATA;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (!ack_on) begin
                            ack_on <= 1'b1;
                            sda_oe <= 1'b1;
                        end else begin
                            ack_on  <= 1'b0;
                            bit_cnt <= 3'd0;
                            state   <= nxt_state;
                            if (nxt_state == ST_RDATA) begin
                                tx_sh  <= rd_byte[6:0];
                                sda_oe <= ~rd_byte[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                            ack_on <= 1'b0;
                            ptr    <= ptr + ADDR_W'(1);
                        end else begin
                            sda_oe  <= ~tx_sh[6];
                            tx_sh   <= {tx_sh[5:0], 1'b0};
                            bit_cnt <= bit_cnt + 3'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        if (sda_lvl) state  <= ST_IDLE;
                        else         ack_on <= 1'b1;
                    end else if (scl_fall && ack_on) begin
                        ack_on  <= 1'b0;
                        bit_cnt <= 3'd0;
                        state   <= ST_RDATA;
                        tx_sh   <= rd_byte[6:0];
                        sda_oe  <= ~rd_byte[7];
                    end
                end
                default: ;
            endcase
        end
    end

    // Programming request: one pulse at STOP when data bytes were taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrote        <= 1'b0;
            prog_start_o <= 1'b0;
        end else begin
            prog_start_o <= stop_ev && wrote;
            if (stop_ev)     wrote <= 1'b0;
            else if (mem_we) wrote <= 1'b1;
        end
    end
endmodule

// File: rtl/eeprom_i2c_slave_chk.sv
// Protocol checker for the EEPROM slave engine, attached by bind.
// Assumes: SCL holds each level for several system clocks.
module eeprom_i2c_slave_chk (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_i,
    input logic                   sda_oe,
    input logic                   start_ev,
    input logic                   stop_ev,
    input logic                   prog_start_o,
    input logic                   prog_busy_i,
    input ee_i2c_pkg::slv_state_t state
);
    import ee_i2c_pkg::*;

    // R12
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R11
    start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_DEV) && !sda_oe);

    // R10
    prog_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start_o |=> !prog_start_o);

    // R10
    prog_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start_o |-> $past(stop_ev));

    // R9
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ACK) && ($past(state) == ST_DEV)) |-> !$past(prog_busy_i));

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);
endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_chk chk_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .start_ev(start_ev), .stop_ev(stop_ev), .prog_start_o(prog_start_o),
    .prog_busy_i(prog_busy_i), .state(state)
);

// File: tb/eeprom_i2c_slave_tb_top.sv
// Self-checking bench: a behavioural bus master plus a byte-map model.
module eeprom_i2c_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic strap = 1'b1;
    logic busy = 1'b0;
    logic sda_oe;
    logic prog;
    logic sda_line;
    logic prog_q = 1'b0;
    logic oe_q = 1'b0;
    int   total = 0;
    int   bad = 0;
    int   prog_cnt = 0;
    int   prog_hi = 0;
    logic [7:0] ref_mem [int];
    int   ref_ptr = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_i2c_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .dev_sel_i(strap), .prog_busy_i(busy),
        .prog_start_o(prog)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Pulse counting for the programming request
    always @(posedge clk) begin
        prog_q <= prog;
        if (prog === 1'b1) prog_hi <= prog_hi + 1;
        if (prog === 1'b1 && prog_q !== 1'b1) prog_cnt <= prog_cnt + 1;
    end

    // R12: compared every clock, drive must not move while SCL is high
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_oe !== oe_q && scl_m) check(1'b0, "R12 drive change with SCL high", sda_oe, oe_q);
        end
        oe_q <= sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic put_bit(input bit b);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        ack = (sda_line == 1'b0);
        tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q); scl_m = 1'b0; tick(Q);
        end
        put_bit(!give_ack);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] hdr(input logic [3:0] typ, input logic s,
                                       input logic [1:0] blk, input logic rw);
        return {typ, s, blk, rw};
    endfunction

    task automatic do_write(input logic [1:0] blk, input logic [7:0] word,
                            input logic [7:0] data [$], input string req);
        bit ack;
        int a;
        bus_start();
        send_byte(hdr(4'hA, 1'b1, blk, 1'b0), ack); check(ack, {req, " header ack"}, ack, 1);
        send_byte(word, ack); check(ack, {req, " word ack"}, ack, 1);
        a = {22'd0, blk, word};
        foreach (data[i]) begin
            send_byte(data[i], ack); check(ack, {req, " data ack"}, ack, 1);
            ref_mem[a] = data[i];
            a = (a & ~15) | ((a + 1) & 15);
        end
        ref_ptr = a;
        bus_stop();
    endtask

    task automatic do_read(input bit random, input logic [1:0] blk, input logic [7:0] word,
                           input int n, input string req);
        bit ack;
        logic [7:0] b;
        if (random) begin
            bus_start();
            send_byte(hdr(4'hA, 1'b1, blk, 1'b0), ack); check(ack, {req, " dummy header ack"}, ack, 1);
            send_byte(word, ack); check(ack, {req, " dummy word ack"}, ack, 1);
            ref_ptr = {22'd0, blk, word};
        end
        bus_start();
        send_byte(hdr(4'hA, 1'b1, blk, 1'b1), ack); check(ack, {req, " read header ack"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            check(b === ref_mem[ref_ptr], {req, " read data"}, b, ref_mem[ref_ptr]);
            ref_ptr = (ref_ptr + 1) % 1024;
        end
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        bit ack;
        logic [7:0] b;
        logic [7:0] q [$];
        int pc;

        tick(4);
        // R1: reset state
        check(sda_oe === 1'b0, "R1 sda_oe in reset", sda_oe, 0);
        check(prog === 1'b0, "R1 prog_start in reset", prog, 0);
        rst_n = 1'b1;
        tick(20);
        check(sda_oe === 1'b0, "R1 sda_oe after reset", sda_oe, 0);

        // R3 byte write, R10 one programming pulse
        q = '{8'hC3};
        do_write(2'd2, 8'h35, q, "R3");
        check(prog_cnt == 1, "R10 pulse after write", prog_cnt, 1);

        // R6 random read, R8 no data after NACK
        bus_start();
        send_byte(hdr(4'hA, 1'b1, 2'd2, 1'b0), ack); check(ack, "R6 dummy header ack", ack, 1);
        send_byte(8'h35, ack); check(ack, "R6 dummy word ack", ack, 1);
        bus_start();
        send_byte(hdr(4'hA, 1'b1, 2'd2, 1'b1), ack); check(ack, "R6 read header ack", ack, 1);
        recv_byte(1'b0, b); check(b === 8'hC3, "R6 random read data", b, 8'hC3);
        recv_byte(1'b0, b); check(b === 8'hFF, "R8 line released after NACK", b, 8'hFF);
        bus_stop();
        ref_ptr = 'h236;
        check(prog_cnt == 1, "R10 no pulse after read", prog_cnt, 1);

        // R4 page write wrapping inside the 16-byte page
        q = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4};
        do_write(2'd1, 8'h1E, q, "R4");
        check(prog_cnt == 2, "R10 pulse after page write", prog_cnt, 2);
        do_read(1'b1, 2'd1, 8'h10, 3, "R4 R7 wrapped page");
        check(ref_mem['h120] === 8'bx || !ref_mem.exists('h120), "R4 no spill model", 0, 0);

        // R5 current address read continues after the last access
        do_read(1'b1, 2'd1, 8'h1E, 1, "R5 setup");
        do_read(1'b0, 2'd0, 8'h00, 1, "R5 current read");

        // R7 full-pointer wrap 1023 -> 0
        q = '{8'h5A};
        do_write(2'd3, 8'hFF, q, "R7 last cell");
        q = '{8'h96};
        do_write(2'd0, 8'h00, q, "R7 first cell");
        do_read(1'b1, 2'd3, 8'hFF, 2, "R7 wrap read");

        // R2 mismatched strap bit and type code are ignored
        pc = prog_cnt;
        bus_start();
        send_byte(hdr(4'hA, 1'b0, 2'd2, 1'b0), ack); check(!ack, "R2 strap mismatch nack", ack, 0);
        send_byte(8'h35, ack); check(!ack, "R2 ignored word", ack, 0);
        send_byte(8'h11, ack); check(!ack, "R2 ignored data", ack, 0);
        bus_stop();
        bus_start();
        send_byte(hdr(4'hB, 1'b1, 2'd2, 1'b0), ack); check(!ack, "R2 type mismatch nack", ack, 0);
        send_byte(8'h35, ack); check(!ack, "R2 ignored word after type", ack, 0);
        bus_stop();
        check(prog_cnt == pc, "R10 no pulse when ignored", prog_cnt, pc);
        do_read(1'b1, 2'd2, 8'h35, 1, "R2 cell unchanged");

        // R9 busy refuses the header
        busy = 1'b1;
        bus_start();
        send_byte(hdr(4'hA, 1'b1, 2'd0, 1'b0), ack); check(!ack, "R9 nack while busy", ack, 0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte(hdr(4'hA, 1'b1, 2'd0, 1'b0), ack); check(ack, "R9 ack after busy", ack, 1);
        bus_stop();
        check(prog_cnt == pc, "R10 no pulse for header only", prog_cnt, pc);

        // R11 START in the middle of a data byte restarts header reception
        bus_start();
        send_byte(hdr(4'hA, 1'b1, 2'd0, 1'b0), ack); check(ack, "R11 header ack", ack, 1);
        send_byte(8'h40, ack); check(ack, "R11 word ack", ack, 1);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        send_byte(hdr(4'hA, 1'b1, 2'd0, 1'b0), ack); check(ack, "R11 header after abort", ack, 1);
        send_byte(8'h00, ack); check(ack, "R11 word after abort", ack, 1);
        bus_start();
        send_byte(hdr(4'hA, 1'b1, 2'd0, 1'b1), ack); check(ack, "R11 read header", ack, 1);
        recv_byte(1'b0, b); check(b === 8'h96, "R11 read after abort", b, 8'h96);
        bus_stop();
        check(prog_cnt == pc, "R10 no pulse for aborted byte", prog_cnt, pc);

        tick(10);
        check(prog_hi == prog_cnt, "R10 pulses one cycle wide", prog_hi, prog_cnt);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule